// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

The block watches a parameterized set of interrupt lines and chooses which of them, if any, should be handed to the processor next. Each line has an enable bit, a pending bit and an 8-bit urgency value where smaller numbers are more urgent. A run-time grouping setting `g` cuts every urgency value into two parts. The upper `8-g` bits form the preemption level. The lower `g` bits form a subpriority. Only the preemption level can interrupt a handler that is already running. The subpriority only breaks ties among waiting requests.

The processor sees a registered request flag and a line number. It accepts a request with a one-cycle `take` pulse and later reports the end of that handler with a one-cycle `ret` pulse. An internal stack keeps the raw urgency value of every handler that is in progress. A new request is offered only when the stack is empty, or when the best candidate's preemption level is strictly more urgent than the level on top of the stack. Levels are always derived from the stored raw values under the current grouping, so a change of grouping applies at once to handlers already in progress.

A small word-addressed write/read port configures the block. Enable-set is at address 0 and enable-clear is at address 1; a read of either returns the enable mask. Address 2 reads the pending mask. Address 3 holds the grouping. Address 4+i holds the urgency of line i.

Top module: `irq_group_arbiter`

## Requirements
- R1: After a synchronous reset, all enables and pending bits are 0, every urgency is 0, grouping reads 4, the stack is empty and `req_valid` is 0.
- R2: A write to address 0 sets the enable bits where the data has a 1. A write to address 1 clears them. Zero bits have no effect. Reading address 0 or 1 returns the enable mask in bits [N-1:0].
- R3: A 0-to-1 transition on `irq[i]` sets pending bit i, which can be read at address 2. A line held high does not set its bit again. A disabled line keeps its pending bit and is never requested.
- R4: Among the lines that are both pending and enabled, the chosen line has the most urgent preemption level, then the most urgent subpriority. If both are equal, the lowest line number is chosen.
- R5: Writing a value of 0 to 4 to address 3 (bits [2:0]) sets the grouping g, and the preemption level becomes urgency >> g. Values 5 to 7 are ignored. Address 3 reads back g.
- R6: With no handler in progress, any pending enabled line is requested. `req_valid` and `req_line` are registered, so they reflect the state one clock earlier.
- R7: While a handler is in progress, a request is raised only if the candidate's preemption level is strictly less than the level on top of the stack. An equal or larger level waits.
- R8: A `take` while `req_valid` is 1 clears the pending bit of `req_line`, pushes that line's urgency onto the stack, and drives `req_valid` to 0 in the next cycle. A `take` while `req_valid` is 0 is ignored.
- R9: A `ret` pops the stack, after which waiting requests are re-evaluated. A `ret` with an empty stack is ignored. A `ret` in the same cycle as an accepted `take` is ignored.
- R10: Changing the grouping while handlers are in progress makes the next comparison use the new split, applied to the raw urgencies stored on the stack.
- R11: A write to address 4+i stores data bits [7:0] as the urgency of line i, and a read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | NUM_LINES | Interrupt lines, rising edge sets pending |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| req_valid | output | 1 | A line may be taken now |
| req_line | output | IDX_W | Number of the offered line |
| take | input | 1 | Processor accepts the offered line |
| ret | input | 1 | Processor finished the innermost handler |

## Verification
The bench focuses on these cases:
- Two requests that share a preemption level but differ in subpriority, where a design that compared only the level would pick the lower line number.
- A request equal to the running level, which a non-strict comparison would wrongly let nest.
- A grouping change while a handler is running, which a design that stored cut-down levels instead of raw values would get wrong.
- A `take` on the cycle a request appears, where a missing one-cycle blanking would offer an already-cleared line again.
- A line held high, which a level-sensitive latch would re-pend.
- A disabled line with a latched pending bit, which must not be offered.
- A `ret` or `take` that arrives with nothing to act on, which a design without guards would turn into a stack underflow or a spurious push.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W    = 8;
  localparam int GRP_W     = 3;
  localparam int GRP_MAX   = 4;
  localparam int GRP_RESET = 4;
  localparam int DATA_W    = 32;

  // register word addresses
  localparam int A_EN_SET  = 0;
  localparam int A_EN_CLR  = 1;
  localparam int A_PEND    = 2;
  localparam int A_GROUP   = 3;
  localparam int A_PRIO    = 4;

  typedef logic [PRIO_W-1:0] prio_t;

  // preemption level of a raw urgency value under grouping g
  function automatic prio_t level_of(prio_t p, logic [GRP_W-1:0] g);
    return prio_t'(p >> g);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq,
  input  logic                 clr,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] irq_prev;
  logic [NUM_LINES-1:0] clr_mask;

  assign clr_mask = clr ? (NUM_LINES'(1) << clr_idx) : '0;

  // a new edge in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= '0;
      pend     <= '0;
    end else begin
      irq_prev <= irq;
      pend     <= (pend & ~clr_mask) | (irq & ~irq_prev);
    end
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]             cand,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic                             found,
  output logic [IDX_W-1:0]                 idx,
  output prio_t                            best
);
  // the raw value orders by level first and subpriority second;
  // strict compare keeps the lowest index on a full tie
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  prio_t            din,
  output prio_t            top,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  prio_t mem [DEPTH];

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign top   = empty ? '0 : mem[PTR_W'(count - 1'b1)];

  always_ff @(posedge clk) begin
    if (push && !full) mem[PTR_W'(count)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                 count <= '0;
    else if (push && !full)  count <= count + 1'b1;
    else if (pop && !empty)  count <= count - 1'b1;
  end
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = NUM_LINES,
  localparam int ADDR_W = $clog2(NUM_LINES + A_PRIO + 1),
  localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 req_valid,
  output logic [IDX_W-1:0]     req_line,
  input  logic                 take,
  input  logic                 ret
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_LINES-1:0]             en_q;
  logic [GRP_W-1:0]                 grp_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_LINES-1:0]             pend_q;

  logic             in_prio;
  logic [IDX_W-1:0] prio_sel;
  logic             take_ok, ret_ok;
  logic             found;
  logic [IDX_W-1:0] best_idx;
  prio_t            best_prio, top_prio;
  logic             stk_empty, stk_full;
  logic [CNT_W-1:0] stk_count;
  logic             allow;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata;

  assign in_prio  = (reg_addr >= ADDR_W'(A_PRIO)) &&
                    (reg_addr <  ADDR_W'(A_PRIO + NUM_LINES));
  assign prio_sel = IDX_W'(reg_addr - ADDR_W'(A_PRIO));

  assign take_ok = take && req_valid;
  assign ret_ok  = ret && !stk_empty && !take_ok;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      grp_q  <= GRP_W'(GRP_RESET);
      prio_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(A_EN_SET))
        en_q <= en_q | reg_wdata[NUM_LINES-1:0];
      else if (reg_addr == ADDR_W'(A_EN_CLR))
        en_q <= en_q & ~reg_wdata[NUM_LINES-1:0];
      else if (reg_addr == ADDR_W'(A_GROUP)) begin
        if (reg_wdata[GRP_W-1:0] <= GRP_W'(GRP_MAX))
          grp_q <= reg_wdata[GRP_W-1:0];
      end else if (in_prio)
        prio_q[prio_sel] <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_EN_SET) || reg_addr == ADDR_W'(A_EN_CLR))
      rd_mux = DATA_W'(en_q);
    else if (reg_addr == ADDR_W'(A_PEND))
      rd_mux = DATA_W'(pend_q);
    else if (reg_addr == ADDR_W'(A_GROUP))
      rd_mux = DATA_W'(grp_q);
    else if (in_prio)
      rd_mux = DATA_W'(prio_q[prio_sel]);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  irq_pend_bank #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq),
    .clr     (take_ok),
    .clr_idx (req_line),
    .pend    (pend_q)
  );

  irq_prio_select #(.NUM_LINES(NUM_LINES)) u_sel (
    .cand  (pend_q & en_q),
    .prio  (prio_q),
    .found (found),
    .idx   (best_idx),
    .best  (best_prio)
  );

  irq_level_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (take_ok),
    .pop   (ret_ok),
    .din   (prio_q[req_line]),
    .top   (top_prio),
    .empty (stk_empty),
    .full  (stk_full),
    .count (stk_count)
  );

  assign allow = found &&
                 (stk_empty || level_of(best_prio, grp_q) < level_of(top_prio, grp_q));

  // blank for one cycle after any stack change so a stale offer never shows
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_line  <= '0;
    end else begin
      req_valid <= allow && !take_ok && !ret_ok;
      req_line  <= best_idx;
    end
  end
endmodule

// File: rtl/irq_group_arbiter_chk.sv
module irq_group_arbiter_chk #(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 take,
  input logic                 ret,
  input logic                 req_valid,
  input logic [IDX_W-1:0]     req_line,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] en,
  input logic [CNT_W-1:0]     depth
);
  logic [NUM_LINES-1:0] pend_d, en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_d <= '0;
      en_d   <= '0;
    end else begin
      pend_d <= pend;
      en_d   <= en;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!req_valid && depth == '0));

  a_r3_offer_pending_enabled: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (pend_d[req_line] && en_d[req_line]));

  a_r8_take_pushes: assert property (@(posedge clk) disable iff (rst)
    (take && req_valid && depth < CNT_W'(DEPTH)) |=> depth == CNT_W'($past(depth) + 1'b1));

  a_r8_take_blanks: assert property (@(posedge clk) disable iff (rst)
    (take && req_valid) |=> !req_valid);

  a_r9_ret_pops: assert property (@(posedge clk) disable iff (rst)
    (ret && !(take && req_valid) && depth != '0) |=> depth == CNT_W'($past(depth) - 1'b1));

  a_r9_ret_empty_ignored: assert property (@(posedge clk) disable iff (rst)
    (ret && !(take && req_valid) && depth == '0) |=> depth == '0);

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));
endmodule

bind irq_group_arbiter irq_group_arbiter_chk #(
  .NUM_LINES (NUM_LINES),
  .DEPTH     (DEPTH),
  .IDX_W     (IDX_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .take      (take),
  .ret       (ret),
  .req_valid (req_valid),
  .req_line  (req_line),
  .pend      (pend_q),
  .en        (en_q),
  .depth     (stk_count)
);

// File: tb/irq_group_arbiter_test.sv
`timescale 1ns/1ps
module irq_group_arbiter_test;
  localparam int NL = 16;
  localparam int AW = $clog2(NL + 5);
  localparam int IW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          req_valid;
  logic [IW-1:0] req_line;
  logic          take = 1'b0;
  logic          ret = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_group_arbiter #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst(rst), .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_line(req_line), .take(take), .ret(ret)
  );

  // behavioural reference state
  bit m_en [NL];
  bit m_pend [NL];
  bit m_prev [NL];
  int m_prio [NL];
  int m_grp;
  int m_stack [$];
  bit m_valid;
  int m_line;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    int exp_rd, bi, bp, nl;
    bit found, allow, take_ok, ret_ok, nv;
    int a;
    a = int'(reg_addr);
    exp_rd = 0;
    if (a == 0 || a == 1) begin
      for (int i = 0; i < NL; i++) if (m_en[i]) exp_rd |= (1 << i);
    end else if (a == 2) begin
      for (int i = 0; i < NL; i++) if (m_pend[i]) exp_rd |= (1 << i);
    end else if (a == 3) exp_rd = m_grp;
    else if (a >= 4 && a < 4 + NL) exp_rd = m_prio[a-4];
    found = 0; bi = 0; bp = 256;
    for (int i = 0; i < NL; i++)
      if (m_pend[i] && m_en[i] && m_prio[i] < bp) begin
        found = 1; bi = i; bp = m_prio[i];
      end
    allow = found && (m_stack.size() == 0 ||
                      (bp >> m_grp) < (m_stack[$] >> m_grp));
    take_ok = take && m_valid;
    ret_ok  = ret && m_stack.size() > 0 && !take_ok;
    nv = allow && !take_ok && !ret_ok;
    nl = bi;
    if (take_ok) begin
      m_pend[m_line] = 0;
      m_stack.push_back(m_prio[m_line]);
    end
    if (ret_ok) void'(m_stack.pop_back());
    for (int i = 0; i < NL; i++) begin
      if (irq[i] && !m_prev[i]) m_pend[i] = 1;
      m_prev[i] = irq[i];
    end
    if (reg_we) begin
      if (a == 0) begin
        for (int i = 0; i < NL; i++) if (reg_wdata[i]) m_en[i] = 1;
      end else if (a == 1) begin
        for (int i = 0; i < NL; i++) if (reg_wdata[i]) m_en[i] = 0;
      end else if (a == 3) begin
        if (int'(reg_wdata[2:0]) <= 4) m_grp = int'(reg_wdata[2:0]);
      end else if (a >= 4 && a < 4 + NL) m_prio[a-4] = int'(reg_wdata[7:0]);
    end
    m_valid = nv;
    m_line  = nl;
    @(posedge clk);
    @(negedge clk);
    check(tag, "req_valid", int'(req_valid), int'(m_valid));
    if (m_valid) check(tag, "req_line", int'(req_line), m_line);
    check(tag, "reg_rdata", int'(reg_rdata), exp_rd);
    reg_we = 0; take = 0; ret = 0;
  endtask

  task automatic wr(int addr, int data, string tag);
    reg_we = 1; reg_addr = AW'(addr); reg_wdata = data;
    tick(tag);
  endtask
  task automatic rd(int addr, string tag);
    reg_addr = AW'(addr);
    tick(tag);
  endtask
  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask
  task automatic pulse2(int l0, int l1, string tag);
    irq[l0] = 1; irq[l1] = 1; tick(tag);
    irq[l0] = 0; irq[l1] = 0; tick(tag);
  endtask
  task automatic do_take(string tag); take = 1; tick(tag); endtask
  task automatic do_ret(string tag);  ret = 1;  tick(tag); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_en[i] = 0; m_pend[i] = 0; m_prev[i] = 0; m_prio[i] = 0;
    end
    m_grp = 4; m_valid = 0; m_line = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "req_valid in reset", int'(req_valid), 0);
    rst = 0;
    // R1 reset values
    rd(3, "R1"); rd(4, "R1"); rd(0, "R1"); rd(2, "R1");
    // R11 urgency registers
    wr(4+0, 'h40, "R11"); wr(4+1, 'h145, "R11"); wr(4+2, 'h23, "R11");
    wr(4+3, 'h21, "R11"); wr(4+4, 'h40, "R11"); wr(4+5, 'h10, "R11");
    wr(4+6, 'h3F, "R11"); wr(4+7, 'h80, "R11");
    rd(4+1, "R11"); rd(4+3, "R11");
    // R2 enable set / clear, zeros ignored
    wr(0, 'h00F0, "R2"); wr(0, 0, "R2"); wr(1, 0, "R2");
    wr(1, 'h0030, "R2"); rd(0, "R2"); wr(0, 'h000F, "R2"); rd(1, "R2");
    // R3 disabled line keeps pending, never offered; held level
    irq[8] = 1;
    pulse2(4, 4, "R3");
    rd(2, "R3"); idle(3, "R3");
    // R6 enable it with empty stack
    wr(0, 'h10, "R6"); idle(2, "R6");
    // R8 take it
    do_take("R8"); rd(2, "R8"); idle(1, "R8");
    do_take("R8"); // ignored, nothing offered
    // R7 equal level waits
    pulse2(0, 0, "R7"); idle(3, "R7");
    // R4 same level, subpriority decides; then R7 preemption
    pulse2(2, 3, "R4"); idle(1, "R4");
    do_take("R4"); idle(2, "R7");
    do_ret("R9"); idle(2, "R9");
    do_take("R9"); idle(1, "R9");
    do_ret("R9"); idle(1, "R9");
    do_ret("R9"); idle(2, "R9");
    do_take("R9"); do_ret("R9"); idle(1, "R9");
    do_ret("R9"); do_ret("R9"); rd(2, "R9");
    // R4 full tie, lowest line wins
    pulse2(0, 4, "R4"); idle(1, "R4");
    do_take("R4"); idle(2, "R4");
    do_take("R4"); do_ret("R4"); do_ret("R4"); idle(1, "R4");
    // R5 grouping register
    wr(3, 7, "R5"); rd(3, "R5"); wr(3, 2, "R5"); rd(3, "R5");
    wr(3, 4, "R5");
    // R10 regroup with a handler running
    wr(0, 'h02, "R10");
    pulse2(1, 1, "R10"); idle(1, "R10");
    do_take("R10");
    pulse2(0, 0, "R10"); idle(2, "R10");
    wr(3, 0, "R10"); idle(2, "R10");
    do_take("R10"); idle(1, "R10");
    // R5 group 0: 0x3F against 0x40 now preempts, with take and ret together
    pulse2(6, 6, "R5"); take = 1; ret = 1; tick("R9");
    idle(1, "R5");
    do_ret("R9"); do_ret("R9"); do_ret("R9"); idle(2, "R9");
    // R3 held line 8: enable it, take it, no re-pend while high
    wr(0, 'h100, "R3"); idle(1, "R3");
    do_take("R3"); idle(3, "R3"); rd(2, "R3");
    do_ret("R3"); idle(2, "R3");
    irq[8] = 0; idle(1, "R3");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule